// File: doc/BRIEF.md
# Serial/Parallel Gain-Word Control Latch

This block is the digital control front end of a 5-bit step-gain stage. It keeps a gain control word in an output register that drives the gain setting. The word can be loaded in either of two ways, chosen by a mode pin: as a three-wire serial load (data, shift clock and latch enable), or as a parallel word. A fast system clock oversamples every external pin through a two-flop synchronizer and finds the rising edges of the shift clock.

The latch-enable pin has two jobs. In serial mode, while it is high it commits the input register to the output and blocks shift-clock edges, so the word cannot change while it is being transferred. In parallel mode the input register follows the parallel pins. Latch enable then works as a transparent latch. Held high, the output tracks the pins directly. Pulsed, it performs a latched update.

Whenever the output register takes a value different from the one it held, a one-cycle update strobe is raised.

Top module: `gain_word_ctl`

## Requirements
- R1: While rst_n is low, the input register and the gain output are cleared to 5'b00000 and gain_upd_o is 0.
- R2: With mode_ser_i high, each rising edge of sclk_i captures sdata_i into bit 0 of the input register, and the older bits move one place toward bit 4. A 5-bit word is therefore sent most-significant bit first.
- R3: While latch_i is high (after synchronization), the gain output is loaded from the input register.
- R4: In serial mode, rising edges of sclk_i that occur while latch_i is high leave the input register unchanged.
- R5: With mode_ser_i low, sdata_i and sclk_i have no effect, and the input register follows par_word_i on every cycle.
- R6: In parallel mode with latch_i held high, gain_o follows changes on par_word_i.
- R7: In parallel mode, par_word_i may be changed while latch_i is low, and a later latch_i pulse moves the new word to gain_o.
- R8: In every mode, gain_o does not change while latch_i is low.
- R9: If more than 5 bits are shifted, only the last 5 are kept. If fewer than 5 are shifted, the earlier contents move up toward bit 4.
- R10: gain_upd_o is high for one cycle exactly when gain_o takes a value different from its previous one. Loading an equal word raises no strobe.
- R11: A latch_i pulse that lasts one system clock period is enough to commit the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x faster than the shortest external pulse |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ser_i | input | 1 | 1 = serial loading, 0 = parallel loading (asynchronous) |
| sdata_i | input | 1 | Serial data bit (asynchronous) |
| sclk_i | input | 1 | Shift clock; acts on its rising edge (asynchronous) |
| latch_i | input | 1 | Latch enable: commits the word and masks the shift clock (asynchronous) |
| par_word_i | input | 5 | Parallel gain word (asynchronous) |
| gain_o | output | 5 | Output gain control word |
| gain_upd_o | output | 1 | One-cycle strobe when gain_o takes a new value |

## Verification
The bound checker checks the following on every cycle:
- gain_o never moves unless the synchronized latch enable was high.
- The update strobe coincides exactly with a change of gain_o.
- The input register stays frozen in serial mode while latch enable is high.
- The input register tracks the synchronized parallel pins in parallel mode.
- The reset state holds.

Some behaviour can only be shown by the bench's scenarios, because it depends on a complete pin sequence:
- the serial bit order and the value of a whole shifted word;
- the keep-last-five and partial-shift results;
- serial pins being ignored in parallel mode;
- direct versus latched parallel operation;
- a one-cycle latch pulse being enough.

// File: rtl/gwc_pkg.sv
// Package: shared widths and pin-bundle type for the gain-word control latch.
// Assumes: the gain word width is fixed at build time by GW_WIDTH.
package gwc_pkg;
    localparam int GW_WIDTH   = 5;
    localparam int GW_STAGES  = 2;
    localparam int CTL_PINS   = 4;

    // Control pins in the order they are packed ahead of the parallel word.
    typedef struct packed {
        logic mode_ser;
        logic sdata;
        logic sclk;
        logic latch;
    } ctl_pins_t;
endpackage

// File: rtl/gwc_sync.sv
// Module: gwc_sync
// Multi-stage synchronizer for a vector of asynchronous pins, plus one
// extra sample register so that rising edges can be found.
// Assumes: every input pulse lasts at least one clk period. Bits are
// synchronized independently, so the inputs must have settled before a
// consumer acts on them together.
module gwc_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] rise_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev_q;

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage retimes the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronized value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg[LAST];
    end

    assign sync_o = stg[LAST];
    assign rise_o = stg[LAST] & ~prev_q;
endmodule

// File: rtl/gwc_in_reg.sv
// Module: gwc_in_reg
// Input register. In serial mode it shifts left, taking the new bit into
// bit 0 on each enabled shift event. In parallel mode it loads the
// parallel word on every cycle.
// Assumes: shift_en already carries the latch-enable mask.
module gwc_in_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_mode,
    input  logic         shift_en,
    input  logic         sdata,
    input  logic [W-1:0] par_word,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_q;

    // Pick between parallel follow and serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n)         word_q <= '0;
        else if (!ser_mode) word_q <= par_word;
        else if (shift_en)  word_q <= {word_q[W-2:0], sdata};
    end

    assign word_o = word_q;
endmodule

// File: rtl/gwc_out_reg.sv
// Module: gwc_out_reg
// Output control register. While the level-sensitive load is high it is
// transparent to the next word. It raises a one-cycle strobe whenever its
// value changes.
// Assumes: load is already synchronized to clk.
module gwc_out_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] next_word,
    output logic [W-1:0] gain_o,
    output logic         upd_o
);
    logic [W-1:0] gain_q;
    logic         upd_q;
    logic         differs;

    assign differs = (next_word != gain_q);

    // Hold the word, and take a new one only while load is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gain_q <= '0;
        else if (load && differs)   gain_q <= next_word;
    end

    // Strobe for the cycle after a real change is committed.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= load && differs;
    end

    assign gain_o = gain_q;
    assign upd_o  = upd_q;
endmodule

// File: rtl/gain_word_ctl.sv
// Module: gain_word_ctl (top)
// Front end for a serial/parallel gain word. It synchronizes all pins, masks
// the shift clock while latch enable is high, and moves the input register
// to the output register while latch enable is high.
// Assumes: clk is at least 4x faster than the shortest external pulse, and
// serial data is stable on the pin before the shift clock rises.
module gain_word_ctl
    import gwc_pkg::*;
#(
    parameter int W      = GW_WIDTH,
    parameter int STAGES = GW_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_ser_i,
    input  logic         sdata_i,
    input  logic         sclk_i,
    input  logic         latch_i,
    input  logic [W-1:0] par_word_i,
    output logic [W-1:0] gain_o,
    output logic         gain_upd_o
);
    localparam int PINS = CTL_PINS + W;

    ctl_pins_t        ctl_raw, ctl_s, ctl_rise;
    logic [PINS-1:0]  pins_raw, pins_s, pins_rise;
    logic             mode_s, latch_s, shift_en;
    logic [W-1:0]     par_s, in_word;

    // Bundle the raw pins for the synchronizer.
    always_comb begin
        ctl_raw.mode_ser = mode_ser_i;
        ctl_raw.sdata    = sdata_i;
        ctl_raw.sclk     = sclk_i;
        ctl_raw.latch    = latch_i;
    end
    assign pins_raw = {ctl_raw, par_word_i};

    gwc_sync #(.WIDTH(PINS), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_raw),
        .sync_o  (pins_s),
        .rise_o  (pins_rise)
    );

    assign ctl_s    = ctl_pins_t'(pins_s[PINS-1:W]);
    assign ctl_rise = ctl_pins_t'(pins_rise[PINS-1:W]);
    assign par_s    = pins_s[W-1:0];
    assign mode_s   = ctl_s.mode_ser;
    assign latch_s  = ctl_s.latch;

    // A shift-clock edge counts only in serial mode and only while latch enable is low.
    assign shift_en = mode_s && ctl_rise.sclk && !latch_s;

    gwc_in_reg #(.W(W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_mode (mode_s),
        .shift_en (shift_en),
        .sdata    (ctl_s.sdata),
        .par_word (par_s),
        .word_o   (in_word)
    );

    gwc_out_reg #(.W(W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (latch_s),
        .next_word (in_word),
        .gain_o    (gain_o),
        .upd_o     (gain_upd_o)
    );
endmodule

// File: rtl/gwc_checker.sv
// Module: gwc_checker
// Cycle-by-cycle properties of gain_word_ctl. It is attached through bind.
module gwc_checker #(
    parameter int W = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] gain_o,
    input logic         gain_upd_o,
    input logic         mode_s,
    input logic         latch_s,
    input logic [W-1:0] par_s,
    input logic [W-1:0] in_reg
);
    // R1: reset clears the output and the strobe.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (gain_o == '0 && !gain_upd_o));

    // R8: the output moves only after a cycle with latch enable high.
    p_hold_when_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_o) |-> $past(latch_s));

    // R10: a change of the output always raises the strobe.
    p_change_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_o) |-> gain_upd_o);

    // R10: the strobe never fires without a change of the output.
    p_strobe_means_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd_o |-> !$stable(gain_o));

    // R4: in serial mode the input register is frozen while latch enable is high.
    p_mask_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && latch_s) |=> $stable(in_reg));

    // R5: in parallel mode the input register tracks the parallel pins.
    p_par_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_s |=> (in_reg == $past(par_s)));
endmodule

bind gain_word_ctl gwc_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gain_o     (gain_o),
    .gain_upd_o (gain_upd_o),
    .mode_s     (mode_s),
    .latch_s    (latch_s),
    .par_s      (par_s),
    .in_reg     (in_word)
);

// File: tb/gain_word_ctl_tb.sv
module gain_word_ctl_tb;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_ser_i = 1'b0;
    logic         sdata_i = 1'b0;
    logic         sclk_i = 1'b0;
    logic         latch_i = 1'b0;
    logic [W-1:0] par_word_i = '0;
    logic [W-1:0] gain_o;
    logic         gain_upd_o;

    int n_checks = 0;
    int n_fails  = 0;
    int upd_cnt  = 0;
    logic [W-1:0] exp_gain = '0;

    always #5 clk = ~clk;

    gain_word_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ser_i (mode_ser_i),
        .sdata_i    (sdata_i),
        .sclk_i     (sclk_i),
        .latch_i    (latch_i),
        .par_word_i (par_word_i),
        .gain_o     (gain_o),
        .gain_upd_o (gain_upd_o)
    );

    // Count update strobes.
    always @(posedge clk) if (rst_n && gain_upd_o) upd_cnt <= upd_cnt + 1;

    // Table entries: {serial mode flag, word}.
    localparam logic [5:0] VEC [8] = '{
        6'b1_10110, 6'b1_01001, 6'b0_11100, 6'b1_00001,
        6'b0_00111, 6'b1_11111, 6'b0_10000, 6'b1_01010
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sdata_i = b; tick(3);
        sclk_i = 1'b1; tick(3);
        sclk_i = 1'b0; tick(3);
    endtask

    task automatic shift_bits(input logic [7:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
    endtask

    task automatic pulse_latch(input int width);
        latch_i = 1'b1; tick(width);
        latch_i = 1'b0; tick(6);
    endtask

    initial begin
        int c0;
        tick(4);
        check("R1 gain after reset", gain_o, 0);
        check("R1 strobe after reset", gain_upd_o, 0);
        rst_n = 1'b1;
        tick(4);

        // Walk through the table.
        for (int v = 0; v < 8; v++) begin
            logic [W-1:0] w;
            w = VEC[v][W-1:0];
            if (VEC[v][5]) begin
                mode_ser_i = 1'b1; tick(4);
                shift_bits({3'b0, w}, W);
                check("R8 serial hold before latch", gain_o, exp_gain);
                pulse_latch(3);
                exp_gain = w;
                check("R2 R3 serial word committed", gain_o, exp_gain);
            end else begin
                mode_ser_i = 1'b0; par_word_i = w; tick(8);
                check("R7 R8 parallel hold while latch low", gain_o, exp_gain);
                pulse_latch(3);
                exp_gain = w;
                check("R7 latched parallel update", gain_o, exp_gain);
            end
        end

        // R6: direct parallel operation with latch enable held high.
        mode_ser_i = 1'b0; latch_i = 1'b1;
        par_word_i = 5'b00011; tick(8);
        check("R6 direct follow 1", gain_o, 5'b00011);
        par_word_i = 5'b11000; tick(8);
        check("R6 direct follow 2", gain_o, 5'b11000);
        latch_i = 1'b0; tick(6);
        exp_gain = 5'b11000;

        // R5: serial pins have no effect in parallel mode.
        par_word_i = 5'b01101; tick(6);
        shift_bits(8'b00010010, W);
        check("R8 no change without latch", gain_o, exp_gain);
        pulse_latch(3);
        exp_gain = 5'b01101;
        check("R5 parallel word wins over serial pins", gain_o, exp_gain);

        // R9: a partial shift keeps the older bits, moved up.
        par_word_i = 5'b10110; tick(6);
        mode_ser_i = 1'b1; tick(4);
        shift_bits(8'b11, 2);
        pulse_latch(3);
        exp_gain = 5'b11011;
        check("R9 partial shift", gain_o, exp_gain);

        // R9: seven bits shifted, so only the last five remain.
        shift_bits(8'b1010011, 7);
        pulse_latch(3);
        exp_gain = 5'b10011;
        check("R9 overlong shift keeps last five", gain_o, exp_gain);

        // R4: shift edges while latch enable is high are masked.
        c0 = upd_cnt;
        latch_i = 1'b1; tick(6);
        shift_bits(8'b01100, W);
        latch_i = 1'b0; tick(6);
        pulse_latch(3);
        check("R4 masked shifts leave word", gain_o, exp_gain);
        check("R10 no strobe for unchanged word", upd_cnt - c0, 0);

        // R10 and R11: a one-cycle latch pulse commits a new word with one strobe.
        c0 = upd_cnt;
        shift_bits(8'b00101, W);
        pulse_latch(1);
        exp_gain = 5'b00101;
        check("R11 one-cycle latch pulse", gain_o, exp_gain);
        check("R10 single strobe per change", upd_cnt - c0, 1);

        // R1: reset again in mid-operation.
        rst_n = 1'b0; tick(3);
        check("R1 mid-run reset clears gain", gain_o, 0);
        rst_n = 1'b1; mode_ser_i = 1'b1; tick(6);
        pulse_latch(3);
        check("R1 input register cleared", gain_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule